// File: doc/BRIEF.md
# Memory-card host status and interrupt unit

This block is the event-collection corner of a memory-card host controller. The command and data paths of the controller are outside it. They report what happened as single-cycle strobes on `ev_set`, and each strobe latches a sticky bit in a 16-bit status word. A card-detect input is synchronised to the clock and mirrored on `cover_out`. A card arriving (a low-to-high change) latches its own status bit.

Software reaches the block over a plain register bus with one write strobe and a combinational read. Status bits are cleared by writing ones to them. A 15-bit enable mask selects which status bits drive the single interrupt line. Writing the controller enable bit as 0, or pulsing the soft-reset bit, returns status, mask, enable and the FIFO-threshold/DMA configuration word to their reset values. The card-detect tracking is left untouched by either reset path.

Register map (word addresses): 0 control, 1 status, 2 interrupt enable, 3 buffer configuration, 4 system control. Any other address reads 0 and ignores writes.

Top module: `card_stat_irq`

## Requirements
- R1: `irq` is a registered level. It equals the OR of (status AND mask) as held one clock earlier, so it changes on the edge after the edge that changed status or mask.
- R2: Writing address 1 clears exactly the status bits written as 1. Bits written as 0 keep their value.
- R3: The interrupt-enable register at address 2 keeps only bits 14:0. Bit 15 always reads 0.
- R4: A rising edge on `cd_in` sets status bit 1 on the (SYNC_STAGES+1)th clock edge after the change. A falling edge sets no status bit.
- R5: `cover_out` follows the level of `cd_in` with the same SYNC_STAGES+1 edge delay, in both directions.
- R6: A write to address 0 stores bit 11 as the controller enable, which reads back at bit 11. When that bit is written as 0, status, mask and the buffer configuration return to their reset values.
- R7: A write to address 4 with bit 2 set performs the same reset as R6 and also clears the enable. A write to address 4 with bit 2 clear changes nothing, and address 4 always reads 0.
- R8: After either reset path, status and mask read 0, the enable reads 0, and address 3 reads 0x1F00 (almost-full threshold 0x1F in bits 12:8, almost-empty threshold 0 in bits 4:0, both DMA enables in bits 15 and 7 at 0).
- R9: When an event strobe and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R10: Only `ev_set` bits 0 (command done), 3 (block transfer done), 7 (command timeout), 10 (FIFO almost full), 11 (FIFO almost empty), 12 (OCR busy) and 14 (card error) set status. All other `ev_set` bits are ignored.
- R11: Address 3 stores and reads back bits 15, 12:8, 7 and 4:0 of the written word, with all other bits reading 0. An internal reset (R6/R7) in the same cycle as an event strobe leaves status at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data for `reg_addr` |
| ev_set | input | 16 | Single-cycle event strobes, one per status bit |
| cd_in | input | 1 | Asynchronous card-detect level |
| cover_out | output | 1 | Synchronised card-detect level |
| irq | output | 1 | Interrupt request level |

## Verification
The bench builds the block with its defaults: ADDR_W of 3, which gives one unused address (7) for idle cycles, and SYNC_STAGES of 2. With two stages the card-detect latency is three edges, so the bench can wait out both directions of the input change in a few cycles. Status priority is walked through a vector table that mixes event strobes with clear writes on overlapping bits. Directed tests then cover both reset paths, the mask width and the one-cycle lag of the interrupt.

// File: rtl/card_stat_pkg.sv
package card_stat_pkg;
  localparam int STAT_W = 16;

  // register word addresses
  localparam int A_CTRL = 0;
  localparam int A_STAT = 1;
  localparam int A_MASK = 2;
  localparam int A_BUF  = 3;
  localparam int A_SYS  = 4;

  // bit positions software decodes
  localparam int CTRL_EN_BIT = 11;
  localparam int SYS_RST_BIT = 2;
  localparam int ST_CARD_IN  = 1;

  // status bits that event strobes may set
  localparam logic [STAT_W-1:0] EV_SETTABLE = 16'h5C89;
  localparam logic [STAT_W-1:0] MASK_KEEP   = 16'h7FFF;
  localparam logic [STAT_W-1:0] BUF_KEEP    = 16'h9F9F;
  localparam logic [STAT_W-1:0] BUF_RST     = 16'h1F00;
endpackage

// File: rtl/cd_track.sv
module cd_track #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cd_in,
  output logic cd_level,
  output logic cd_rise
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      level_q <= 1'b0;
    end else begin
      sync_q  <= {sync_q[SYNC_STAGES-2:0], cd_in};
      level_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign cd_rise  = sync_q[SYNC_STAGES-1] & ~level_q;
  assign cd_level = level_q;
endmodule

// File: rtl/ctrl_regs.sv
module ctrl_regs
  import card_stat_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [STAT_W-1:0] reg_wdata,
  output logic              enable,
  output logic [STAT_W-1:0] buf_cfg,
  output logic              soft_rst
);
  logic wr_ctrl, wr_sys, wr_buf;

  assign wr_ctrl  = reg_wr && (reg_addr == ADDR_W'(A_CTRL));
  assign wr_sys   = reg_wr && (reg_addr == ADDR_W'(A_SYS));
  assign wr_buf   = reg_wr && (reg_addr == ADDR_W'(A_BUF));
  assign soft_rst = (wr_ctrl && !reg_wdata[CTRL_EN_BIT]) ||
                    (wr_sys && reg_wdata[SYS_RST_BIT]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable  <= 1'b0;
      buf_cfg <= BUF_RST;
    end else begin
      if (wr_ctrl)       enable <= reg_wdata[CTRL_EN_BIT];
      else if (soft_rst) enable <= 1'b0;
      if (soft_rst)      buf_cfg <= BUF_RST;
      else if (wr_buf)   buf_cfg <= reg_wdata & BUF_KEEP;
    end
  end
endmodule

// File: rtl/stat_core.sv
module stat_core
  import card_stat_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [STAT_W-1:0] reg_wdata,
  input  logic [STAT_W-1:0] ev_set,
  input  logic              cd_rise,
  output logic [STAT_W-1:0] stat_q,
  output logic [STAT_W-1:0] mask_q,
  output logic              irq
);
  logic [STAT_W-1:0] set_v, clr_v, stat_d;

  always_comb begin
    set_v = ev_set & EV_SETTABLE;
    set_v[ST_CARD_IN] = set_v[ST_CARD_IN] | cd_rise;
    clr_v = (reg_wr && reg_addr == ADDR_W'(A_STAT)) ? reg_wdata : '0;
    // set has priority over clear
    stat_d = soft_rst ? '0 : ((stat_q & ~clr_v) | set_v);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
      irq    <= 1'b0;
    end else begin
      stat_q <= stat_d;
      if (soft_rst)
        mask_q <= '0;
      else if (reg_wr && reg_addr == ADDR_W'(A_MASK))
        mask_q <= reg_wdata & MASK_KEEP;
      irq <= |(stat_q & mask_q);
    end
  end
endmodule

// File: rtl/card_stat_irq.sv
module card_stat_irq
  import card_stat_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic [15:0]       ev_set,
  input  logic              cd_in,
  output logic              cover_out,
  output logic              irq
);
  logic              cd_rise, enable, soft_rst;
  logic [STAT_W-1:0] buf_cfg, stat_q, mask_q;

  cd_track #(.SYNC_STAGES(SYNC_STAGES)) u_cd (
    .clk(clk), .rst_n(rst_n), .cd_in(cd_in),
    .cd_level(cover_out), .cd_rise(cd_rise)
  );

  ctrl_regs #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .enable(enable), .buf_cfg(buf_cfg),
    .soft_rst(soft_rst)
  );

  stat_core #(.ADDR_W(ADDR_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .ev_set(ev_set),
    .cd_rise(cd_rise), .stat_q(stat_q), .mask_q(mask_q), .irq(irq)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_W'(A_CTRL): reg_rdata[CTRL_EN_BIT] = enable;
      ADDR_W'(A_STAT): reg_rdata = stat_q;
      ADDR_W'(A_MASK): reg_rdata = mask_q;
      ADDR_W'(A_BUF):  reg_rdata = buf_cfg;
      default:         reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/card_stat_irq_chk.sv
module card_stat_irq_chk
  import card_stat_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [15:0]       reg_wdata,
  input logic [15:0]       reg_rdata,
  input logic [15:0]       ev_set,
  input logic              cd_rise,
  input logic              soft_rst,
  input logic [15:0]       stat_q,
  input logic [15:0]       mask_q,
  input logic [15:0]       buf_cfg,
  input logic              cover_out,
  input logic              irq
);
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & mask_q) == '0) |=> !irq); // R1

  AST_W1C_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(A_STAT) && ev_set == '0 && !cd_rise)
    |=> (stat_q == ($past(stat_q) & ~$past(reg_wdata)))); // R2

  AST_MASK_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_q[15]); // R3

  AST_CARD_IN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cover_out) && !$past(soft_rst)) |-> stat_q[ST_CARD_IN]); // R4

  AST_SOFT_RST_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (stat_q == '0 && mask_q == '0 && buf_cfg == BUF_RST)); // R8

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && (ev_set & EV_SETTABLE) != '0)
    |=> ((stat_q & $past(ev_set & EV_SETTABLE)) == $past(ev_set & EV_SETTABLE))); // R9

  AST_SYS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(A_SYS)) |-> (reg_rdata == '0)); // R7
endmodule

bind card_stat_irq card_stat_irq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_set(ev_set),
  .cd_rise(cd_rise), .soft_rst(soft_rst), .stat_q(stat_q),
  .mask_q(mask_q), .buf_cfg(buf_cfg), .cover_out(cover_out), .irq(irq)
);

// File: tb/card_stat_irq_tb.sv
`timescale 1ns/1ps
module card_stat_irq_tb;
  localparam int ADDR_W = 3;
  localparam logic [2:0] NOWR = 3'd7;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_wr = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [15:0]       reg_wdata = '0;
  logic [15:0]       reg_rdata;
  logic [15:0]       ev_set = '0;
  logic              cd_in = 1'b0;
  logic              cover_out, irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  card_stat_irq #(.ADDR_W(ADDR_W), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_set(ev_set),
    .cd_in(cd_in), .cover_out(cover_out), .irq(irq)
  );

  // {addr, wdata, ev_set, expected status}; addr 7 = no write
  localparam logic [50:0] VEC [0:7] = '{
    {NOWR, 16'h0000, 16'h0001, 16'h0001},  // R10 command done
    {NOWR, 16'h0000, 16'h0088, 16'h0089},  // R10 block done + timeout
    {3'd1, 16'h0008, 16'h0000, 16'h0081},  // R2 clear one bit
    {3'd1, 16'h0081, 16'h0001, 16'h0001},  // R9 set beats clear
    {NOWR, 16'h0000, 16'hFFFF, 16'h5C89},  // R10 non-event bits ignored
    {3'd1, 16'hFFFF, 16'h0000, 16'h0000},  // R2 clear all
    {3'd1, 16'h0000, 16'h4000, 16'h4000},  // R2 zero write keeps, card error
    {3'd1, 16'h4000, 16'h0000, 16'h0000}   // R2
  };

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic cycle(input logic [2:0] a, input logic [15:0] d, input logic [15:0] ev);
    @(negedge clk);
    reg_wr    = (a != NOWR);
    reg_addr  = a;
    reg_wdata = d;
    ev_set    = ev;
    @(negedge clk);
    reg_wr = 1'b0;
    ev_set = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    rd(3'd1, v); check("R8 status at reset", v, 16'h0000);
    rd(3'd2, v); check("R8 mask at reset", v, 16'h0000);
    rd(3'd0, v); check("R8 enable at reset", v, 16'h0000);
    rd(3'd3, v); check("R8 buffer cfg at reset", v, 16'h1F00);
    check("R1 irq at reset", {15'd0, irq}, 16'h0000);

    cycle(3'd0, 16'h0800, 16'h0);
    rd(3'd0, v); check("R6 enable readback", v, 16'h0800);

    for (int i = 0; i < 8; i++) begin
      cycle(VEC[i][50:48], VEC[i][47:32], VEC[i][31:16]);
      rd(3'd1, v);
      check($sformatf("R2/R9/R10 vector %0d", i), v, VEC[i][15:0]);
    end

    // R3 mask width
    cycle(3'd2, 16'hFFFF, 16'h0);
    rd(3'd2, v); check("R3 mask bit15 dropped", v, 16'h7FFF);
    cycle(3'd2, 16'h0001, 16'h0);

    // R1 irq lag: event at edge E, irq after E+1
    @(negedge clk); ev_set = 16'h0001;
    @(negedge clk); ev_set = '0;
    check("R1 irq not yet", {15'd0, irq}, 16'h0000);
    @(negedge clk);
    check("R1 irq raised", {15'd0, irq}, 16'h0001);
    cycle(3'd2, 16'h0000, 16'h0);
    @(negedge clk);
    check("R1 irq off after mask clear", {15'd0, irq}, 16'h0000);
    cycle(3'd1, 16'hFFFF, 16'h0);

    // R11 buffer config fields
    cycle(3'd3, 16'hFFFF, 16'h0);
    rd(3'd3, v); check("R11 buffer cfg fields", v, 16'h9F9F);

    // R4/R5 card detect
    @(negedge clk); cd_in = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R5 cover lags", {15'd0, cover_out}, 16'h0000);
    @(negedge clk);
    check("R5 cover rises", {15'd0, cover_out}, 16'h0001);
    rd(3'd1, v); check("R4 card in bit", v, 16'h0002);
    cycle(3'd1, 16'h0002, 16'h0);
    cd_in = 1'b0;
    repeat (5) @(negedge clk);
    check("R5 cover falls", {15'd0, cover_out}, 16'h0000);
    rd(3'd1, v); check("R4 fall sets nothing", v, 16'h0000);

    // R6 reset by enable 0
    cycle(3'd2, 16'h00FF, 16'h0);
    cycle(NOWR, 16'h0, 16'h0008);
    cycle(3'd0, 16'h0000, 16'h0001);
    rd(3'd1, v); check("R6 status cleared (R11 beats event)", v, 16'h0000);
    rd(3'd2, v); check("R6 mask cleared", v, 16'h0000);
    rd(3'd3, v); check("R6 buffer cfg reset", v, 16'h1F00);

    // R7 system reset
    cycle(3'd0, 16'h0800, 16'h0);
    cycle(3'd2, 16'h0010, 16'h0);
    cycle(NOWR, 16'h0, 16'h0080);
    cycle(3'd4, 16'hFFFB, 16'h0);
    rd(3'd1, v); check("R7 bit2 clear no reset status", v, 16'h0080);
    rd(3'd2, v); check("R7 bit2 clear no reset mask", v, 16'h0010);
    rd(3'd0, v); check("R7 bit2 clear keeps enable", v, 16'h0800);
    rd(3'd4, v); check("R7 reads zero", v, 16'h0000);
    cycle(3'd4, 16'h0004, 16'h0);
    rd(3'd1, v); check("R7 status reset", v, 16'h0000);
    rd(3'd2, v); check("R7 mask reset", v, 16'h0000);
    rd(3'd0, v); check("R7 enable cleared", v, 16'h0000);
    rd(3'd3, v); check("R8 buffer cfg after sys reset", v, 16'h1F00);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule